// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter

This block turns one 32-bit ARINC 429 word into a return-to-zero stream on two rail outputs: `rail_one` pulses for a 1 bit, `rail_zero` pulses for a 0 bit, and both low is the null state between bits and between words. It runs from a single clock at four times the bit rate, so every bit cell lasts four clocks. The host writes the word one byte at a time through an 8-bit port and watches `ready`, `busy_n` and `err`.

Two loading schemes are offered. In extended mode (`mode_ext`=1) all four bytes are buffered first and the word goes out as a whole. In byte mode (`mode_ext`=0) only the first byte has to be present before the send begins, and each following byte is written while earlier bits are still being shifted out. A byte that arrives too late aborts the word with an underwrite error that stops the transmitter until the host reads status (`stat_rd`). A word is released only when the transmitter enable is set and the active-low clear-to-send input is low. In self-test mode the rails stay quiet and the stream appears on the loop-back outputs meant for a receiver.

Top module: `a429_word_tx`

## Requirements
- R1: After reset `busy_n`=1, `ready`=1, `err`=0, and `rail_zero`, `rail_one`, `loop_zero`, `loop_one` are all 0.
- R2: Each bit takes four clocks: two clocks with `rail_one` high (bit 1) or `rail_zero` high (bit 0), then two clocks with both low. The two rails are never high together.
- R3: A word starts only when the buffer holds enough bytes (all four in extended mode, the first in byte mode), `tx_en`=1 and `cts_n`=0. If any of these is missing, `busy_n` stays 1.
- R4: The first byte written carries word bits 1..8 with `wr_byte[0]` as bit 1. Bytes two, three and four carry bits 9..16, 17..24 and 25..32. Bit 1 is sent first.
- R5: With `par_en`=1, bit 32 is sent as odd parity over bits 1..31, so the sent word has an odd number of ones. With `par_en`=0, bit 32 is `wr_byte[7]` of the fourth byte.
- R6: `busy_n` is low from the first clock of bit 1 through the last clock of bit 32, which is 128 clocks for a complete word, and high otherwise.
- R7: In extended mode `ready` is 1 while fewer than four bytes are held and no word is being sent, and 0 otherwise. In byte mode `ready` is 1 when the byte needed next may be written. A write with `ready`=0 is ignored.
- R8: In byte mode, if byte k+1 has not been written by the end of the cell of the last bit of byte k, `err` goes to 1, the word is abandoned and the rails return to null.
- R9: While `err`=1 no word is sent, `ready` is 0 and writes are ignored. A `stat_rd` pulse clears `err`, and so does reset.
- R10: After the last bit cell of a word, at least four null bit times (16 clocks) pass before the next word starts. A word that is already loaded starts on the clock right after the gap, which gives 19 null clocks between the last active clock of one word and the first of the next.
- R11: With `self_test`=1 both rails stay low, and `loop_one`/`loop_zero` carry the stream with the R2 timing. With `self_test`=0 the loop-back outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, four times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ext | input | 1 | 1 = four-byte extended buffer, 0 = byte-at-a-time |
| par_en | input | 1 | 1 = bit 32 replaced by odd parity |
| self_test | input | 1 | 1 = rails held low, stream on loop-back outputs |
| tx_en | input | 1 | Transmitter enable control bit |
| cts_n | input | 1 | Clear-to-send gate, active low |
| wr_stb | input | 1 | Data byte write strobe, one clock per byte |
| wr_byte | input | 8 | Data byte |
| stat_rd | input | 1 | Status read pulse; clears the underwrite error |
| ready | output | 1 | A byte may be written |
| busy_n | output | 1 | Low while a word is being sent |
| err | output | 1 | Underwrite error flag |
| rail_zero | output | 1 | Zero rail, high during the active half of a 0 bit |
| rail_one | output | 1 | One rail, high during the active half of a 1 bit |
| loop_zero | output | 1 | Zero rail to the internal receiver in self-test |
| loop_one | output | 1 | One rail to the internal receiver in self-test |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four bytes per word, four-clock cells and a four-bit gap. A word therefore costs about 150 clocks, which makes it practical to walk a single one through all 32 bit positions, alternating parity on and off, so that byte order, bit order and the parity slot are all exercised. The short cell also makes the byte-mode deadline easy to hit exactly. The same configuration lets the bench pin down the exact gap length between words that run back to back, the abort point of an underwrite, and the gating by enable and clear-to-send.

// File: rtl/a429_tx_pkg.sv
// Shared types for the ARINC 429 word transmitter.
package a429_tx_pkg;
    // Transmitter sequencing states
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,   // waiting for a loaded buffer and release
        TX_SEND = 2'd1,   // shifting bit cells out
        TX_GAP  = 2'd2,   // enforced null time after a word
        TX_HALT = 2'd3    // underwrite error, waiting for status read
    } tx_state_e;
endpackage

// File: rtl/a429_tx_buffer.sv
// Byte buffer for one transmit word.
// Collects up to N_BYTES bytes in write order; slot g holds word bits
// g*BYTE_W .. g*BYTE_W+BYTE_W-1. Assumes the caller only asserts load
// when a slot is free. flush empties the buffer and takes priority.
module a429_tx_buffer #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 4,
    localparam int WORD_W = BYTE_W * N_BYTES,
    localparam int CNT_W  = $clog2(N_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              flush,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  fill
);
    logic [CNT_W-1:0] fill_q;

    // Count of bytes held; cleared by flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            fill_q <= '0;
        else if (load && fill_q < CNT_W'(N_BYTES))
            fill_q <= fill_q + CNT_W'(1);
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;
        // Capture the byte written while this slot is the next free one
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (load && fill_q == CNT_W'(g))
                slot_q <= din;
        end
        assign word[g*BYTE_W +: BYTE_W] = slot_q;
    end

    assign fill = fill_q;

    // R7
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> fill_q < CNT_W'(N_BYTES));
endmodule

// File: rtl/a429_tx_cell_timer.sv
// Bit cell timer.
// While run is high, phase counts 0..CELL_CLKS-1 and idx advances once
// per cell. restart (or run low) returns both to zero. Assumes CELL_CLKS
// is even and at least 2; the first half of a cell is the active half.
module a429_tx_cell_timer #(
    parameter int CELL_CLKS = 4,
    parameter int IDX_W     = 5,
    localparam int PH_W     = $clog2(CELL_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic [IDX_W-1:0] idx,
    output logic             cell_end,
    output logic             drive_half
);
    logic [PH_W-1:0] phase_q;
    logic [IDX_W-1:0] idx_q;

    // Phase and cell index counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            phase_q <= '0;
            idx_q   <= '0;
        end else if (phase_q == PH_W'(CELL_CLKS - 1)) begin
            phase_q <= '0;
            idx_q   <= idx_q + IDX_W'(1);
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign idx        = idx_q;
    assign cell_end   = run && (phase_q == PH_W'(CELL_CLKS - 1));
    assign drive_half = phase_q < PH_W'(CELL_CLKS / 2);

    // R2
    cell_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_end && !restart) |=> (idx_q == $past(idx_q) + IDX_W'(1)) && (phase_q == '0));
endmodule

// File: rtl/a429_word_tx.sv
// ARINC 429 word transmitter, top level.
// Sends one word of BYTE_W*N_BYTES bits as return-to-zero cells on two
// rails, in extended (whole word buffered) or byte mode (bytes supplied
// during the send). Assumes mode_ext and par_en are static while a word
// is buffered or in flight, and that BYTE_W and N_BYTES are powers of two.
module a429_word_tx
    import a429_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int N_BYTES   = 4,
    parameter int CELL_CLKS = 4,
    parameter int GAP_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ext,
    input  logic              par_en,
    input  logic              self_test,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              stat_rd,
    output logic              ready,
    output logic              busy_n,
    output logic              err,
    output logic              rail_zero,
    output logic              rail_one,
    output logic              loop_zero,
    output logic              loop_one
);
    localparam int WORD_W = BYTE_W * N_BYTES;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int CNT_W  = $clog2(N_BYTES + 1);
    localparam int BB_W   = $clog2(BYTE_W);

    tx_state_e state_q, state_d;

    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  fill;
    logic [IDX_W-1:0]  bit_idx;
    logic              cell_end, drive_half;
    logic [CNT_W-1:0]  cur_byte;
    logic              last_bit, byte_end, gap_done, next_missing;
    logic              load, start, underrun, word_done, flush;
    logic              cur_bit, parity, active, s_one, s_zero;

    // Position of the bit under way
    assign cur_byte     = CNT_W'(bit_idx[IDX_W-1:BB_W]);
    assign last_bit     = bit_idx == IDX_W'(WORD_W - 1);
    assign byte_end     = bit_idx[BB_W-1:0] == BB_W'(BYTE_W - 1);
    assign gap_done     = bit_idx == IDX_W'(GAP_BITS - 1);
    assign next_missing = fill <= cur_byte + CNT_W'(1);

    // Write acceptance window
    always_comb begin
        unique case (state_q)
            TX_SEND: ready = !mode_ext && next_missing && (fill < CNT_W'(N_BYTES));
            TX_HALT: ready = 1'b0;
            default: ready = mode_ext ? (fill < CNT_W'(N_BYTES)) : (fill == '0);
        endcase
    end

    assign load      = wr_stb && ready;
    assign start     = (state_q == TX_IDLE) && tx_en && !cts_n &&
                       (fill >= (mode_ext ? CNT_W'(N_BYTES) : CNT_W'(1)));
    assign word_done = (state_q == TX_SEND) && cell_end && last_bit;
    assign underrun  = (state_q == TX_SEND) && cell_end && !mode_ext &&
                       byte_end && !last_bit && next_missing;
    assign flush     = word_done || underrun;

    // Next-state selection for the sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = TX_SEND;
            TX_SEND: if (word_done) state_d = TX_GAP;
                     else if (underrun) state_d = TX_HALT;
            TX_GAP:  if (cell_end && gap_done) state_d = TX_IDLE;
            TX_HALT: if (stat_rd) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    a429_tx_buffer #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(load), .din(wr_byte),
        .flush(flush), .word(word), .fill(fill)
    );

    a429_tx_cell_timer #(.CELL_CLKS(CELL_CLKS), .IDX_W(IDX_W)) u_cell (
        .clk(clk), .rst_n(rst_n),
        .run((state_q == TX_SEND) || (state_q == TX_GAP)),
        .restart(word_done),
        .idx(bit_idx), .cell_end(cell_end), .drive_half(drive_half)
    );

    // Bit value, with the last slot optionally carrying odd parity
    assign parity  = ~(^word[WORD_W-2:0]);
    assign cur_bit = (last_bit && par_en) ? parity : word[bit_idx];

    // Rail drive and self-test steering
    assign active    = (state_q == TX_SEND) && drive_half;
    assign s_one     = active && cur_bit;
    assign s_zero    = active && !cur_bit;
    assign rail_one  = s_one  && !self_test;
    assign rail_zero = s_zero && !self_test;
    assign loop_one  = s_one  && self_test;
    assign loop_zero = s_zero && self_test;

    assign busy_n = state_q != TX_SEND;
    assign err    = state_q == TX_HALT;

    // R2
    rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_one && rail_zero) && !(loop_one && loop_zero));

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(tx_en) && !$past(cts_n));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !stat_rd) |=> err);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> busy_n && !ready && !rail_one && !rail_zero);

    // R11
    selftest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        self_test |-> !rail_one && !rail_zero);
endmodule

// File: tb/tb_a429_word_tx.sv
// Self-checking bench for a429_word_tx with default parameters.
module tb_a429_word_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ext = 1'b1, par_en = 1'b0, self_test = 1'b0;
    logic tx_en = 1'b1, cts_n = 1'b1, wr_stb = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic ready, busy_n, err, rail_zero, rail_one, loop_zero, loop_one;

    int n_checks = 0, n_fail = 0, cyc = 0;

    a429_word_tx dut (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .par_en(par_en),
        .self_test(self_test), .tx_en(tx_en), .cts_n(cts_n), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .stat_rd(stat_rd), .ready(ready), .busy_n(busy_n),
        .err(err), .rail_zero(rail_zero), .rail_one(rail_one),
        .loop_zero(loop_zero), .loop_one(loop_one)
    );

    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Stream monitor, samples at the falling edge
    logic [31:0] rx_word = '0;
    int rx_cnt = 0, hi_run = 0, null_run = 0, gap_seen = 0;
    int bad_shape = 0, busy_cnt = 0, rails_seen = 0;
    logic prev_act = 1'b0, use_loop = 1'b0, a1, a0;

    always @(negedge clk) begin
        if (rst_n) begin
            a1 = use_loop ? loop_one  : rail_one;
            a0 = use_loop ? loop_zero : rail_zero;
            if (rail_one || rail_zero) rails_seen++;
            if (a1 && a0) bad_shape++;
            if (!busy_n) busy_cnt++;
            if (a1 || a0) begin
                if (!prev_act) begin
                    if (rx_cnt == 0) gap_seen = null_run;
                    else if (null_run != 2) bad_shape++;
                    if (rx_cnt < 32) rx_word[rx_cnt] = a1;
                    rx_cnt++;
                    hi_run = 0;
                end
                hi_run++;
                null_run = 0;
            end else begin
                if (prev_act && hi_run != 2) bad_shape++;
                null_run++;
            end
            prev_act = a1 || a0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        @(posedge clk);
        rx_word = '0; rx_cnt = 0; bad_shape = 0; busy_cnt = 0; rails_seen = 0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; wr_byte = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic p);
        return p ? {~(^w[30:0]), w[30:0]} : w;
    endfunction

    // Wait for a whole word and compare it
    task automatic finish_word(input logic [31:0] exp, input string tag);
        int t = 0;
        while (!(rx_cnt >= 32 && busy_n) && t < 600) begin @(negedge clk); t++; end
        check(rx_word == exp, {tag, " R4 R5 word content"}, rx_word, exp);
        check(busy_cnt == 128, {tag, " R6 busy length"}, busy_cnt, 128);
        check(bad_shape == 0, {tag, " R2 cell shape"}, bad_shape, 0);
    endtask

    task automatic send_ext(input logic [31:0] w, input logic p, input bit chk_gap);
        mon_clear();
        par_en = p;
        for (int k = 0; k < 4; k++) write_byte(w[k*8 +: 8]);
        finish_word(expect_word(w, p), "ext");
        // R10 back-to-back spacing
        if (chk_gap) check(gap_seen == 19, "R10 null gap", gap_seen, 19);
    endtask

    task automatic send_byte(input logic [31:0] w, input logic p);
        int t;
        mon_clear();
        par_en = p;
        write_byte(w[7:0]);
        for (int k = 1; k < 4; k++) begin
            t = 0;
            while (!ready && t < 100) begin @(negedge clk); t++; end
            write_byte(w[k*8 +: 8]);
        end
        finish_word(expect_word(w, p), "byte");
        check(err == 1'b0, "R8 no underwrite when fed in time", err, 0);
    endtask

    initial begin
        int t;
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5C3_0F96; pats[3] = 32'h1234_8765;

        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(err == 1'b0, "R1 err", err, 0);
        check({rail_one, rail_zero, loop_one, loop_zero} == 4'b0, "R1 rails",
              {rail_one, rail_zero, loop_one, loop_zero}, 0);

        // R3 and R7 gating in extended mode
        mon_clear();
        cts_n = 1'b0; tx_en = 1'b1;
        write_byte(8'h5A); write_byte(8'hC3); write_byte(8'h0F);
        idle(20);
        check(busy_n == 1'b1, "R3 no start with three bytes", busy_n, 1);
        check(ready == 1'b1, "R7 ready with three bytes", ready, 1);
        cts_n = 1'b1;
        write_byte(8'h81);
        check(ready == 1'b0, "R7 ready low when full", ready, 0);
        idle(20);
        check(busy_n == 1'b1, "R3 held by cts_n", busy_n, 1);
        tx_en = 1'b0; cts_n = 1'b0;
        idle(20);
        check(busy_n == 1'b1, "R3 held by tx_en", busy_n, 1);
        write_byte(8'hEE);
        check(rx_cnt == 0, "R7 write ignored when full", rx_cnt, 0);
        tx_en = 1'b1;
        t = 0;
        while (busy_n && t < 10) begin @(negedge clk); t++; end
        check(busy_n == 1'b0, "R3 start once released", busy_n, 0);
        check(ready == 1'b0, "R7 ready low while sending", ready, 0);
        finish_word(32'h810F_C35A, "gate");

        // Walking one over every position, parity alternating
        for (int i = 0; i < 32; i++) send_ext(32'h1 << i, i[0], 1'b1);
        for (int i = 0; i < 4; i++) begin
            send_ext(pats[i], 1'b0, 1'b1);
            send_ext(pats[i], 1'b1, 1'b1);
        end

        // Byte mode words
        mode_ext = 1'b0;
        for (int i = 0; i < 4; i++) begin
            send_byte(pats[i], 1'b0);
            send_byte(pats[i] ^ 32'h0F0F_F0F0, 1'b1);
        end

        // R8 underwrite and R9 halt
        idle(20);
        mon_clear();
        write_byte(8'h3C);
        t = 0;
        while (!err && t < 100) begin @(negedge clk); t++; end
        check(err == 1'b1, "R8 underwrite flagged", err, 1);
        check(rx_cnt == 8, "R8 abort after first byte", rx_cnt, 8);
        check(rx_word[7:0] == 8'h3C, "R4 first byte bits", rx_word[7:0], 8'h3C);
        idle(20);
        check(err == 1'b1, "R9 error held", err, 1);
        check(busy_n == 1'b1 && rx_cnt == 8, "R8 rails null after abort", rx_cnt, 8);
        check(ready == 1'b0, "R9 ready low in error", ready, 0);
        write_byte(8'h11);
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        check(err == 1'b0, "R9 cleared by status read", err, 0);
        idle(30);
        check(busy_n == 1'b1 && rx_cnt == 8, "R9 write during error ignored", rx_cnt, 8);
        check(ready == 1'b1, "R7 byte mode ready when empty", ready, 1);
        send_byte(32'hC0DE_1357, 1'b1);

        // R11 self-test
        mode_ext = 1'b1; self_test = 1'b1; use_loop = 1'b1;
        send_ext(32'h6B2D_90F1, 1'b0, 1'b0);
        check(rails_seen == 0, "R11 rails quiet in self-test", rails_seen, 0);
        self_test = 1'b0; use_loop = 1'b0;
        send_ext(32'h0000_00FF, 1'b0, 1'b1);
        check(loop_one == 1'b0 && loop_zero == 1'b0, "R11 loop quiet outside self-test",
              {loop_one, loop_zero}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule